// File: doc/BRIEF.md
# Rule 110 Cellular Automaton Array

This block holds a row of single-bit cells, each either alive (1) or dead (0), and advances the whole row by one generation on every clock where the step input is high. Every cell computes its next value from a fixed sum-of-products expression of three inputs: its left neighbour, its own value and its right neighbour. That expression is the elementary rule 110, which is hard-wired into each cell and cannot be changed. All cells latch on the same edge.

A parallel load port writes a whole starting pattern in one cycle. A generation counter reports how many steps have completed since the last load or reset. The row width can be set anywhere from 8 to 256 cells. A parameter chooses what the two end cells see beyond the edge of the row: either a constant dead neighbour, or the cell at the opposite end, which closes the row into a ring.

Top module: `ca110_array`

## Requirements
- R1: While `rst_n` is low, every cell and the generation counter read zero. Reset takes effect without a clock, and its release takes effect through a two-stage synchronizer.
- R2: A cycle with `load_i` high writes `load_row_i` into `row_o` and clears `gen_o` to zero. Both changes appear after that clock edge.
- R3: When `load_i` and `step_i` are both high, the load wins. The row takes the loaded pattern and `gen_o` reads zero.
- R4: A cycle with `step_i` high and `load_i` low updates every cell at the same time. Bit i+1 is the left neighbour of bit i, and bit i-1 is its right neighbour. With the pattern written as left, centre, right, the patterns 111, 100 and 000 give 0, and 110, 101, 011, 010 and 001 give 1.
- R5: A cycle with both `load_i` and `step_i` low leaves `row_o` and `gen_o` unchanged.
- R6: With `WRAP_EDGES` = 0, the left neighbour of the top bit and the right neighbour of bit 0 are taken as dead.
- R7: With `WRAP_EDGES` = 1, the left neighbour of the top bit is bit 0, and the right neighbour of bit 0 is the top bit.
- R8: `gen_o` goes up by one on each step cycle, and it wraps modulo 2^`GEN_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low; asserts asynchronously and releases synchronously |
| load_i | input | 1 | Writes `load_row_i` into the row and clears the counter |
| load_row_i | input | NUM_CELLS | Starting pattern |
| step_i | input | 1 | Advances one generation |
| row_o | output | NUM_CELLS | Current cell values |
| gen_o | output | GEN_W | Generations completed since the last load or reset |

## Verification
The embedded assertions check, on every cycle, the following:
- a load captures the pattern and clears the counter, and it wins over a step;
- an idle cycle changes nothing;
- a step adds one to the counter;
- each cell follows the rule for the patterns 001 and 111 against the values its neighbours actually present.

Some behaviour can only be shown by the bench scenarios, which compare rows against an independent lookup-table model. This covers:
- the full rule across whole rows over several generations;
- the difference between the two edge modes;
- counter wrap-around;
- the asynchronous clearing of a running row.

// File: rtl/ca110_pkg.sv
package ca110_pkg;

  localparam int unsigned MIN_CELLS = 8;
  localparam int unsigned MAX_CELLS = 256;

  // Rule 110 written as a sum of products over (left, centre, right).
  function automatic logic rule110_sop(input logic lft, input logic ctr, input logic rgt);
    return (ctr & ~rgt) | (~ctr & rgt) | (~lft & ctr);
  endfunction

endpackage

// File: rtl/ca110_rst_sync.sv
module ca110_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/ca110_cell.sv
module ca110_cell
  import ca110_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic step,
  input  logic left_nb,
  input  logic right_nb,
  output logic state_q
);

  logic state_d;
  logic state_en;

  always_comb begin
    state_en = load | step;
    if (load) state_d = load_val;
    else      state_d = rule110_sop(left_nb, state_q, right_nb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= 1'b0;
    else if (state_en) state_q <= state_d;
  end

  // R4: a lone live right neighbour brings a dead cell to life
  a_r4_cell_birth: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !left_nb && !state_q && right_nb) |=> state_q);

  // R4: a full neighbourhood kills the cell
  a_r4_cell_crowd: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && left_nb && state_q && right_nb) |=> !state_q);

endmodule

// File: rtl/ca110_gen_counter.sv
module ca110_gen_counter #(
  parameter int unsigned GEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [GEN_W-1:0] count_q
);

  logic [GEN_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = clr | inc;
    if (clr) count_d = '0;
    else     count_d = count_q + GEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

endmodule

// File: rtl/ca110_array.sv
module ca110_array
  import ca110_pkg::*;
#(
  parameter int unsigned NUM_CELLS  = 16,
  parameter bit          WRAP_EDGES = 1'b0,
  parameter int unsigned GEN_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [NUM_CELLS-1:0] load_row_i,
  input  logic                 step_i,
  output logic [NUM_CELLS-1:0] row_o,
  output logic [GEN_W-1:0]     gen_o
);

  localparam int unsigned TOP = NUM_CELLS - 1;

  if (NUM_CELLS < MIN_CELLS || NUM_CELLS > MAX_CELLS) begin : g_bad_size
    $error("NUM_CELLS out of supported range");
  end

  logic                 rst_sync_n;
  logic                 step_only;
  logic [NUM_CELLS-1:0] cells_q;
  logic [NUM_CELLS-1:0] left_in;
  logic [NUM_CELLS-1:0] right_in;
  logic                 edge_left;
  logic                 edge_right;

  ca110_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign step_only = step_i & ~load_i;

  if (WRAP_EDGES) begin : g_ring
    assign edge_left  = cells_q[0];
    assign edge_right = cells_q[TOP];
  end else begin : g_flat
    assign edge_left  = 1'b0;
    assign edge_right = 1'b0;
  end

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    if (i == TOP) begin : g_left_edge
      assign left_in[i] = edge_left;
    end else begin : g_left_inner
      assign left_in[i] = cells_q[i+1];
    end
    if (i == 0) begin : g_right_edge
      assign right_in[i] = edge_right;
    end else begin : g_right_inner
      assign right_in[i] = cells_q[i-1];
    end

    ca110_cell i_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .load     (load_i),
      .load_val (load_row_i[i]),
      .step     (step_i),
      .left_nb  (left_in[i]),
      .right_nb (right_in[i]),
      .state_q  (cells_q[i])
    );
  end

  ca110_gen_counter #(.GEN_W(GEN_W)) i_gen (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (load_i),
    .inc     (step_only),
    .count_q (gen_o)
  );

  assign row_o = cells_q;

  a_r2_load_pattern: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_i |=> (row_o == $past(load_row_i)));

  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && step_i) |=> (gen_o == '0));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_i && !step_i) |=> ($stable(row_o) && $stable(gen_o)));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && !load_i) |=> (gen_o == $past(gen_o) + GEN_W'(1)));

endmodule

// File: tb/test_ca110_array.sv
module test_ca110_array;

  localparam int unsigned N      = 8;
  localparam int unsigned GW     = 4;
  localparam time         CLK_T  = 10ns;
  localparam int unsigned NSEED  = 6;
  localparam int unsigned NGEN   = 5;
  localparam logic [N-1:0] SEEDS [NSEED] = '{8'h01, 8'h80, 8'h5A, 8'hFF, 8'h13, 8'hC4};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_i;
  logic [N-1:0]  load_row_i;
  logic          step_i;
  logic [N-1:0]  row_flat, row_ring;
  logic [GW-1:0] gen_flat, gen_ring;

  int errors = 0;
  int checks = 0;
  logic [N-1:0] exp_flat, exp_ring;

  always #(CLK_T/2) clk = ~clk;

  ca110_array #(.NUM_CELLS(N), .WRAP_EDGES(1'b0), .GEN_W(GW)) i_ca110_array (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_row_i(load_row_i),
    .step_i(step_i), .row_o(row_flat), .gen_o(gen_flat));

  ca110_array #(.NUM_CELLS(N), .WRAP_EDGES(1'b1), .GEN_W(GW)) i_ca110_ring (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_row_i(load_row_i),
    .step_i(step_i), .row_o(row_ring), .gen_o(gen_ring));

  function automatic logic [N-1:0] model(input logic [N-1:0] r, input bit wrap);
    logic [N-1:0] nx;
    for (int i = 0; i < N; i++) begin
      logic l, c, rt;
      l  = (i == N-1) ? (wrap ? r[0] : 1'b0) : r[i+1];
      c  = r[i];
      rt = (i == 0) ? (wrap ? r[N-1] : 1'b0) : r[i-1];
      case ({l, c, rt})
        3'b111, 3'b100, 3'b000: nx[i] = 1'b0;
        default:                nx[i] = 1'b1;
      endcase
    end
    return nx;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic [N-1:0] pat, input logic st);
    load_i = ld; load_row_i = pat; step_i = st;
    @(negedge clk);
    load_i = 1'b0; step_i = 1'b0;
  endtask

  initial begin
    #(CLK_T * 5000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_i = 1'b0; step_i = 1'b0; load_row_i = '0;
    repeat (3) @(negedge clk);
    check("R1 reset row", row_flat, 0);
    check("R1 reset gen", gen_flat, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk: R4 rule, R6 flat edges, R7 ring edges, R2 load
    for (int s = 0; s < NSEED; s++) begin
      cycle(1'b1, SEEDS[s], 1'b0);
      check("R2 load row", row_flat, SEEDS[s]);
      check("R2 load gen", gen_flat, 0);
      exp_flat = SEEDS[s];
      exp_ring = SEEDS[s];
      for (int g = 1; g <= NGEN; g++) begin
        cycle(1'b0, '0, 1'b1);
        exp_flat = model(exp_flat, 1'b0);
        exp_ring = model(exp_ring, 1'b1);
        check("R4/R6 flat step", row_flat, exp_flat);
        check("R4/R7 ring step", row_ring, exp_ring);
        check("R8 gen count", gen_flat, g);
      end
    end

    // R6 vs R7: a single top-bit cell
    cycle(1'b1, 8'h80, 1'b0);
    cycle(1'b0, '0, 1'b1);
    check("R6 flat edge", row_flat, 8'h80);
    check("R7 ring edge", row_ring, 8'h81);

    // R5: idle cycles change nothing
    repeat (3) cycle(1'b0, '0, 1'b0);
    check("R5 hold row", row_flat, 8'h80);
    check("R5 hold gen", gen_flat, 1);

    // R3: load wins over step
    cycle(1'b1, 8'h3C, 1'b1);
    check("R3 load wins row", row_flat, 8'h3C);
    check("R3 load wins gen", gen_flat, 0);

    // R8: the counter wraps after 2^GW steps
    for (int k = 0; k < (1 << GW); k++) cycle(1'b0, '0, 1'b1);
    check("R8 gen wrap", gen_flat, 0);
    cycle(1'b0, '0, 1'b1);
    check("R8 gen after wrap", gen_ring, 1);

    // R1: reset clears a running row without a clock
    cycle(1'b1, 8'hA5, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear row", row_ring, 0);
    check("R1 async clear gen", gen_ring, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b1, 8'h77, 1'b0);
    check("R1 sync release holds", row_flat, 0);
    repeat (2) @(negedge clk);
    cycle(1'b1, 8'h77, 1'b0);
    check("R1 after release", row_flat, 8'h77);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule